// File: doc/BRIEF.md
# I2C Host Register Front End

This block is the software-visible face of an I2C host controller. It decodes a small byte-addressed bus (address, write data, read data, one write strobe and one read strobe) into the registers that drive a separate I2C byte engine. It holds the bus clock divider, a control byte, a transmit byte, a received byte, a command byte and a status byte. The I2C bit timing and the SCL and SDA pads belong to the byte engine and are not part of this block.

Two addresses are shared by direction. A write to the data address loads the transmit byte and a read returns the last received byte. A write to the command address issues an action and a read returns status. The divider can only be programmed while the core is disabled. A command moves through a three-state handshake with the engine: `CMD_IDLE`, `CMD_REQUEST` and `CMD_WAIT`. The ISSUE transition (`CMD_IDLE` to `CMD_REQUEST`) is taken on an accepted command write. The GRANT transition (`CMD_REQUEST` to `CMD_WAIT`) is taken when the engine accepts, and at that point the action bits clear themselves. The FINISH transition (`CMD_WAIT` to `CMD_IDLE`) is taken when the engine reports completion, and at that point the results are latched and the interrupt flag is set. The interrupt output is a level that stays high until software acknowledges it.

Top module: `i2c_host_regs`

## Requirements
- R1: After reset the divider reads 0xFFFF, the control byte and the status byte read 0x00, no engine request is raised and `irq` is low.
- R2: Byte addresses are 0 for the divider low byte, 1 for the divider high byte, 2 for control and 5 to 7 for nothing (they read 0x00). Read data appears on `bus_rdata` in the cycle after the read strobe and is held until the next read. In the control byte, bit 7 is enable, bit 6 is interrupt enable and bit 5 is host mode; bits 4 to 0 read as 0.
- R3: Writes to the divider bytes take effect only while the enable bit is 0. While enable is 1 they are ignored.
- R4: Address 3 is shared by direction. A write sets the transmit byte shown on `eng_txbyte`. A read returns the byte that the engine delivered when a command containing READ finished.
- R5: Command byte bits are 7 START, 6 STOP, 5 READ, 4 WRITE, 3 NACK-after-read and 0 IACK. A command write is accepted only when enable is 1, the handshake is in `CMD_IDLE` and at least one of bits 7 to 4 is set. In the cycle after an accepted write, `eng_req` is high and the matching `eng_*` action outputs are high. START and WRITE may be combined in one write, so that the start condition is followed by the address held in the transmit byte.
- R6: When `eng_accept` is sampled high while a request is pending, `eng_req` and all action outputs are low from the next cycle on.
- R7: Status bit 1 (transfer in progress) is high from the cycle after an accepted command write until the cycle after the engine reports `eng_done`.
- R8: On completion, status bit 0 (interrupt flag) sets. Bit 7 (no acknowledge) and bit 5 (arbitration lost) take the engine's reported values. Bit 6 (bus busy) follows `eng_bus_busy` one cycle late.
- R9: A command write with bit 0 set clears the interrupt flag. If completion arrives in the same cycle, the flag stays set.
- R10: `irq` is high exactly when the interrupt flag and the interrupt enable bit are both 1.
- R11: A command write made while a command is in flight, or while enable is 0, issues nothing and does not change the pending action bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| prescale | output | 16 | Divider value to the engine |
| core_en | output | 1 | Control enable bit |
| host_mode | output | 1 | Control host-mode bit |
| eng_txbyte | output | 8 | Transmit byte |
| eng_req | output | 1 | Command request pending |
| eng_start | output | 1 | Start condition requested |
| eng_stop | output | 1 | Stop condition requested |
| eng_read | output | 1 | Byte read requested |
| eng_write | output | 1 | Byte write requested |
| eng_nack | output | 1 | Answer the read byte with NACK |
| eng_accept | input | 1 | Engine takes the pending command |
| eng_done | input | 1 | Engine finished the command |
| eng_rxbyte | input | 8 | Byte received, valid with eng_done |
| eng_got_nack | input | 1 | No acknowledge seen, valid with eng_done |
| eng_arb_lost | input | 1 | Arbitration lost, valid with eng_done |
| eng_bus_busy | input | 1 | Bus is between start and stop |
| irq | output | 1 | Level interrupt |

## Verification
Every register in this block updates on the edge where the strobe or engine signal is sampled. Engine-facing outputs and `irq` therefore change one cycle after a bus write or a handshake input, and read data appears one cycle after the read strobe. Each task drives its inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge, so every check lands in the first cycle where the result is due. The bus-busy bit is read only after a full idle cycle has passed since its input changed, because it carries one extra cycle of delay.

// File: rtl/i2c_host_pkg.sv
package i2c_host_pkg;

    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 8;
    localparam int NUM_REGS = 5;

    // byte addresses; software depends on these
    localparam int RA_DIV_LO  = 0;
    localparam int RA_DIV_HI  = 1;
    localparam int RA_CTRL    = 2;
    localparam int RA_DATA    = 3;
    localparam int RA_CMDSTAT = 4;

    // command byte bit positions
    localparam int CB_START = 7;
    localparam int CB_STOP  = 6;
    localparam int CB_READ  = 5;
    localparam int CB_WRITE = 4;
    localparam int CB_NACK  = 3;
    localparam int CB_IACK  = 0;

    // control byte bit positions
    localparam int KB_EN   = 7;
    localparam int KB_IEN  = 6;
    localparam int KB_HOST = 5;

    typedef enum logic [1:0] {
        CMD_IDLE    = 2'd0,
        CMD_REQUEST = 2'd1,
        CMD_WAIT    = 2'd2
    } cmd_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rd;
        logic wr;
        logic nack;
    } cmd_bits_t;

    typedef struct packed {
        logic en;
        logic ien;
        logic host;
    } ctrl_bits_t;

endpackage

// File: rtl/i2c_host_decode.sv
module i2c_host_decode
    import i2c_host_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NR = NUM_REGS
) (
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    output logic [NR-1:0] wr_sel,
    output logic          rd_hit
);

    // one write enable per implemented address
    for (genvar i = 0; i < NR; i++) begin : g_wsel
        assign wr_sel[i] = bus_wr && (bus_addr == AW'(i));
    end

    always_comb begin
        rd_hit = bus_rd && (int'(bus_addr) < NR);
    end

    always_comb begin
        if (bus_wr) begin
            assert ($countones(wr_sel) <= 1)
                else $error("decode selected more than one register");
        end
    end

endmodule

// File: rtl/i2c_host_cmd_fsm.sv
module i2c_host_cmd_fsm
    import i2c_host_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_we,
    input  logic [DW-1:0] cmd_wdata,
    input  logic          core_en,
    input  logic          eng_accept,
    input  logic          eng_done,
    output logic          eng_req,
    output cmd_bits_t     cmd_q,
    output logic          in_flight,
    output logic          finish,
    output logic          finish_rd,
    output logic          iack
);

    cmd_state_e state_q, state_d;
    cmd_bits_t  cmd_d;
    logic       was_rd_q, was_rd_d;
    logic       issue;
    logic       grant;

    // a command is taken only when enabled, idle and carrying an action
    always_comb begin
        issue = cmd_we && core_en && (state_q == CMD_IDLE) &&
                (cmd_wdata[CB_START] || cmd_wdata[CB_STOP] ||
                 cmd_wdata[CB_READ]  || cmd_wdata[CB_WRITE]);
        grant = (state_q == CMD_REQUEST) && eng_accept;
    end

    // next state and pending action bits
    always_comb begin
        state_d  = state_q;
        cmd_d    = cmd_q;
        was_rd_d = was_rd_q;
        unique case (state_q)
            CMD_IDLE: begin
                if (issue) begin
                    state_d    = CMD_REQUEST;
                    cmd_d.start = cmd_wdata[CB_START];
                    cmd_d.stop  = cmd_wdata[CB_STOP];
                    cmd_d.rd    = cmd_wdata[CB_READ];
                    cmd_d.wr    = cmd_wdata[CB_WRITE];
                    cmd_d.nack  = cmd_wdata[CB_NACK];
                    was_rd_d    = cmd_wdata[CB_READ];
                end
            end
            CMD_REQUEST: begin
                if (grant) begin
                    state_d = CMD_WAIT;
                    cmd_d   = '0;
                end
            end
            CMD_WAIT: begin
                if (eng_done) begin
                    state_d = CMD_IDLE;
                end
            end
            default: begin
                state_d = CMD_IDLE;
                cmd_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= CMD_IDLE;
            cmd_q    <= '0;
            was_rd_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            cmd_q    <= cmd_d;
            was_rd_q <= was_rd_d;
        end
    end

    // outputs
    always_comb begin
        eng_req   = (state_q == CMD_REQUEST);
        in_flight = (state_q != CMD_IDLE);
        finish    = (state_q == CMD_WAIT) && eng_done;
        finish_rd = finish && was_rd_q;
        iack      = cmd_we && cmd_wdata[CB_IACK];
    end

    // R6: action bits drop the cycle after the engine takes them
    assert_selfclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_accept) |=> (!eng_req && cmd_q == '0));

    // R11: nothing is issued from idle while the core is disabled
    assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_flight && !core_en) |=> !eng_req);

    // R11: a write during a command leaves the pending bits alone
    assert_inflight_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_accept) |=> (eng_req && $stable(cmd_q)));

    // R7: completion always returns to idle
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !in_flight);

endmodule

// File: rtl/i2c_host_status.sv
module i2c_host_status
    import i2c_host_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          finish,
    input  logic          finish_rd,
    input  logic          iack,
    input  logic          in_flight,
    input  logic [DW-1:0] eng_rxbyte,
    input  logic          eng_got_nack,
    input  logic          eng_arb_lost,
    input  logic          eng_bus_busy,
    output logic [DW-1:0] status,
    output logic [DW-1:0] rxbyte,
    output logic          int_flag
);

    logic nack_q;
    logic arb_q;
    logic busy_q;

    // completion outranks acknowledge so no event is lost
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_flag <= 1'b0;
        end else if (finish) begin
            int_flag <= 1'b1;
        end else if (iack) begin
            int_flag <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nack_q <= 1'b0;
            arb_q  <= 1'b0;
        end else if (finish) begin
            nack_q <= eng_got_nack;
            arb_q  <= eng_arb_lost;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxbyte <= '0;
        end else if (finish_rd) begin
            rxbyte <= eng_rxbyte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else begin
            busy_q <= eng_bus_busy;
        end
    end

    always_comb begin
        status       = '0;
        status[7]    = nack_q;
        status[6]    = busy_q;
        status[5]    = arb_q;
        status[1]    = in_flight;
        status[0]    = int_flag;
    end

    // R8: completion raises the flag
    assert_done_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> int_flag);

    // R9: acknowledge without completion clears the flag
    assert_iack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (iack && !finish) |=> !int_flag);

    // R4: received byte only moves on a finished read
    assert_rx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !finish_rd |=> $stable(rxbyte));

endmodule

// File: rtl/i2c_host_regs.sv
module i2c_host_regs
    import i2c_host_pkg::*;
#(
    parameter int          AW          = ADDR_W,
    parameter int          DW          = DATA_W,
    parameter int          DIV_BYTES   = 2,
    parameter logic [15:0] DIV_RESET   = 16'hFFFF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           bus_addr,
    input  logic [DW-1:0]           bus_wdata,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    output logic [DW-1:0]           bus_rdata,
    output logic [DIV_BYTES*DW-1:0] prescale,
    output logic                    core_en,
    output logic                    host_mode,
    output logic [DW-1:0]           eng_txbyte,
    output logic                    eng_req,
    output logic                    eng_start,
    output logic                    eng_stop,
    output logic                    eng_read,
    output logic                    eng_write,
    output logic                    eng_nack,
    input  logic                    eng_accept,
    input  logic                    eng_done,
    input  logic [DW-1:0]           eng_rxbyte,
    input  logic                    eng_got_nack,
    input  logic                    eng_arb_lost,
    input  logic                    eng_bus_busy,
    output logic                    irq
);

    localparam int DIV_W = DIV_BYTES * DW;

    logic [NUM_REGS-1:0] wr_sel;
    logic                rd_hit;
    ctrl_bits_t          ctrl_q;
    cmd_bits_t           cmd_q;
    logic                in_flight;
    logic                finish;
    logic                finish_rd;
    logic                iack;
    logic [DW-1:0]       status;
    logic [DW-1:0]       rxbyte;
    logic                int_flag;
    logic [DW-1:0]       rd_mux;
    logic [DW-1:0]       ctrl_byte;

    i2c_host_decode #(.AW(AW), .NR(NUM_REGS)) u_decode (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .wr_sel   (wr_sel),
        .rd_hit   (rd_hit)
    );

    // divider: one byte lane per address, locked while enabled
    for (genvar b = 0; b < DIV_BYTES; b++) begin : g_div
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prescale[b*DW +: DW] <= DIV_RESET[b*DW +: DW];
            end else if (wr_sel[RA_DIV_LO + b] && !ctrl_q.en) begin
                prescale[b*DW +: DW] <= bus_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_sel[RA_CTRL]) begin
            ctrl_q.en   <= bus_wdata[KB_EN];
            ctrl_q.ien  <= bus_wdata[KB_IEN];
            ctrl_q.host <= bus_wdata[KB_HOST];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_txbyte <= '0;
        end else if (wr_sel[RA_DATA]) begin
            eng_txbyte <= bus_wdata;
        end
    end

    i2c_host_cmd_fsm #(.DW(DW)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_we     (wr_sel[RA_CMDSTAT]),
        .cmd_wdata  (bus_wdata),
        .core_en    (ctrl_q.en),
        .eng_accept (eng_accept),
        .eng_done   (eng_done),
        .eng_req    (eng_req),
        .cmd_q      (cmd_q),
        .in_flight  (in_flight),
        .finish     (finish),
        .finish_rd  (finish_rd),
        .iack       (iack)
    );

    i2c_host_status #(.DW(DW)) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .finish       (finish),
        .finish_rd    (finish_rd),
        .iack         (iack),
        .in_flight    (in_flight),
        .eng_rxbyte   (eng_rxbyte),
        .eng_got_nack (eng_got_nack),
        .eng_arb_lost (eng_arb_lost),
        .eng_bus_busy (eng_bus_busy),
        .status       (status),
        .rxbyte       (rxbyte),
        .int_flag     (int_flag)
    );

    always_comb begin
        ctrl_byte          = '0;
        ctrl_byte[KB_EN]   = ctrl_q.en;
        ctrl_byte[KB_IEN]  = ctrl_q.ien;
        ctrl_byte[KB_HOST] = ctrl_q.host;
    end

    // read side of each address; 3 and 4 differ from their write side
    always_comb begin
        rd_mux = '0;
        unique case (int'(bus_addr))
            RA_DIV_LO:  rd_mux = prescale[0 +: DW];
            RA_DIV_HI:  rd_mux = prescale[DW +: DW];
            RA_CTRL:    rd_mux = ctrl_byte;
            RA_DATA:    rd_mux = rxbyte;
            RA_CMDSTAT: rd_mux = status;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_hit ? rd_mux : '0;
        end
    end

    always_comb begin
        core_en   = ctrl_q.en;
        host_mode = ctrl_q.host;
        eng_start = cmd_q.start;
        eng_stop  = cmd_q.stop;
        eng_read  = cmd_q.rd;
        eng_write = cmd_q.wr;
        eng_nack  = cmd_q.nack;
        irq       = int_flag && ctrl_q.ien;
    end

    // R3: divider never moves while the core is enabled
    assert_div_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        core_en |=> $stable(prescale));

    // R10: interrupt never shows with interrupt enable off
    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel[RA_CTRL] && !bus_wdata[KB_IEN]) |=> !irq);

    // R2: read data only changes after a read strobe
    assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/tb_i2c_host_regs.sv
module tb_i2c_host_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [15:0] prescale;
    logic        core_en, host_mode;
    logic [7:0]  eng_txbyte;
    logic        eng_req, eng_start, eng_stop, eng_read, eng_write, eng_nack;
    logic        eng_accept = 1'b0;
    logic        eng_done = 1'b0;
    logic [7:0]  eng_rxbyte = '0;
    logic        eng_got_nack = 1'b0;
    logic        eng_arb_lost = 1'b0;
    logic        eng_bus_busy = 1'b0;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] rv;

    always #2 clk = ~clk;

    i2c_host_regs dut (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .prescale(prescale), .core_en(core_en), .host_mode(host_mode),
        .eng_txbyte(eng_txbyte), .eng_req(eng_req), .eng_start(eng_start),
        .eng_stop(eng_stop), .eng_read(eng_read), .eng_write(eng_write),
        .eng_nack(eng_nack), .eng_accept(eng_accept), .eng_done(eng_done),
        .eng_rxbyte(eng_rxbyte), .eng_got_nack(eng_got_nack),
        .eng_arb_lost(eng_arb_lost), .eng_bus_busy(eng_bus_busy), .irq(irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic grant();
        @(negedge clk);
        eng_accept = 1'b1;
        @(posedge clk);
        @(negedge clk);
        eng_accept = 1'b0;
    endtask

    task automatic complete(input logic [7:0] rx, input logic nk, input logic al);
        @(negedge clk);
        eng_done = 1'b1; eng_rxbyte = rx; eng_got_nack = nk; eng_arb_lost = al;
        @(posedge clk);
        @(negedge clk);
        eng_done = 1'b0; eng_got_nack = 1'b0; eng_arb_lost = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 eng_req", 16'(eng_req), 16'h0);
        chk("R1 irq", 16'(irq), 16'h0);
        rd(3'd0, rv); chk("R1 div lo", 16'(rv), 16'h00FF);
        rd(3'd1, rv); chk("R1 div hi", 16'(rv), 16'h00FF);
        rd(3'd2, rv); chk("R1 ctrl", 16'(rv), 16'h0000);
        rd(3'd4, rv); chk("R1 status", 16'(rv), 16'h0000);
    endtask

    task automatic t_map();
        wr(3'd0, 8'h34);
        wr(3'd1, 8'h12);
        chk("R2 prescale port", prescale, 16'h1234);
        rd(3'd0, rv); chk("R2 div lo", 16'(rv), 16'h0034);
        rd(3'd1, rv); chk("R2 div hi", 16'(rv), 16'h0012);
        wr(3'd2, 8'hFF);
        rd(3'd2, rv); chk("R2 ctrl unused bits zero", 16'(rv), 16'h00E0);
        chk("R2 host_mode", 16'(host_mode), 16'h1);
        rd(3'd6, rv); chk("R2 unused address", 16'(rv), 16'h0000);
    endtask

    task automatic t_div_lock();
        wr(3'd0, 8'hAA);
        wr(3'd1, 8'hBB);
        chk("R3 prescale locked", prescale, 16'h1234);
        rd(3'd0, rv); chk("R3 div lo locked", 16'(rv), 16'h0034);
    endtask

    task automatic t_start_write();
        wr(3'd3, 8'hA4);
        chk("R4 txbyte", 16'(eng_txbyte), 16'h00A4);
        wr(3'd4, 8'h90);
        chk("R5 req", 16'(eng_req), 16'h1);
        chk("R5 start+write", 16'({eng_start, eng_stop, eng_read, eng_write, eng_nack}), 16'b10010);
        rd(3'd4, rv); chk("R7 tip while pending", 16'(rv), 16'h0002);
        grant();
        chk("R6 req cleared", 16'(eng_req), 16'h0);
        chk("R6 actions cleared", 16'({eng_start, eng_stop, eng_read, eng_write, eng_nack}), 16'h0);
        rd(3'd4, rv); chk("R7 tip while waiting", 16'(rv), 16'h0002);
        complete(8'h00, 1'b1, 1'b0);
        chk("R10 irq raised", 16'(irq), 16'h1);
        rd(3'd4, rv); chk("R8 status nack+flag", 16'(rv), 16'h0081);
        wr(3'd4, 8'h01);
        chk("R9 irq cleared", 16'(irq), 16'h0);
        rd(3'd4, rv); chk("R9 flag cleared", 16'(rv), 16'h0080);
    endtask

    task automatic t_read_cmd();
        wr(3'd4, 8'h28);
        chk("R5 read+nack", 16'({eng_start, eng_stop, eng_read, eng_write, eng_nack}), 16'b00101);
        grant();
        complete(8'h5A, 1'b0, 1'b1);
        rd(3'd3, rv); chk("R4 rx byte", 16'(rv), 16'h005A);
        rd(3'd4, rv); chk("R8 status al+flag", 16'(rv), 16'h0021);
        wr(3'd2, 8'hA0);
        chk("R10 irq masked", 16'(irq), 16'h0);
        wr(3'd2, 8'hE0);
        chk("R10 irq unmasked", 16'(irq), 16'h1);
        wr(3'd4, 8'h01);
    endtask

    task automatic t_ignored();
        wr(3'd4, 8'h20);
        wr(3'd4, 8'h40);
        chk("R11 stop not merged", 16'({eng_stop, eng_read}), 16'b01);
        grant();
        complete(8'h77, 1'b0, 1'b0);
        wr(3'd4, 8'h01);
        wr(3'd2, 8'h60);
        wr(3'd4, 8'h80);
        chk("R11 disabled no req", 16'(eng_req), 16'h0);
        rd(3'd4, rv); chk("R11 disabled no tip", 16'(rv), 16'h0000);
        wr(3'd2, 8'hE0);
    endtask

    task automatic t_busy();
        @(negedge clk);
        eng_bus_busy = 1'b1;
        @(negedge clk);
        rd(3'd4, rv); chk("R8 bus busy", 16'(rv), 16'h0040);
        @(negedge clk);
        eng_bus_busy = 1'b0;
        @(negedge clk);
        rd(3'd4, rv); chk("R8 bus idle", 16'(rv), 16'h0000);
    endtask

    task automatic t_done_vs_iack();
        wr(3'd4, 8'h10);
        grant();
        @(negedge clk);
        eng_done = 1'b1;
        bus_addr = 3'd4; bus_wdata = 8'h01; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        eng_done = 1'b0; bus_wr = 1'b0;
        chk("R9 completion wins", 16'(irq), 16'h1);
        wr(3'd4, 8'h01);
        chk("R9 later iack", 16'(irq), 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_div_lock();
        t_start_write();
        t_read_cmd();
        t_ignored();
        t_busy();
        t_done_vs_iack();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule